// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Bank with Change Interrupt

This block is one eight-pin general-purpose I/O bank that sits on a simple register bus. It holds an output latch, a direction byte, a stored input level per pin and a change-interrupt mask. Each pad is driven from its latch bit and enabled by its direction bit. Pad inputs pass through a synchronizer. Every change of a synchronized level is stored into the level register and can raise an interrupt request. Software reads a merged view of the port: input levels where a pin is an input, latch values where it is an output. Writing ones to the level address inverts the matching latch bits.

A side channel lets other logic (a loopback model, or a peripheral that owns a pin) push a single pin's level straight into the level register. If the push is flagged as a drive, the same bit is also written into the output latch. The full latch value is exported on the pad outputs, with a strobe that marks each latch write. The direction byte has its own strobe. The raw stored levels are exported too, so latch, direction and levels can all be observed together.

Top module: `gpio_bank8`

## Requirements
- R1: After synchronous active-low reset, every register is 0x00. As a result `pad_oe`, `pad_out`, `pin_raw` and `irq` are 0, and a read of any address returns 0x00.
- R2: Address map: 0 = level register, 1 = direction, 2 = output latch, 3 = change mask. A read of address 0 returns `(level & ~dir) | (latch & dir)`, combinationally from the current register values.
- R3: A write to address 0 does not load the level register. Instead, each data bit at 1 inverts the matching latch bit and each bit at 0 leaves it unchanged, whatever the direction.
- R4: A write to address 2 loads the latch. `pad_out` shows the new byte after the clock edge that takes the write, and `port_stb` is high for exactly that one cycle. `port_stb` also pulses after a level-address write and after a driving side-channel update.
- R5: A write to address 1 loads the direction byte. `pad_oe` shows it after the edge, and `dir_stb` is high for that one cycle.
- R6: A change on `pad_in` held steady appears in `pin_raw` three rising edges after it is applied: two synchronizer stages plus the store.
- R7: A side-channel update (`upd_valid`) sets or clears only bit `upd_pin` of the level register, to `upd_level`, without regard to direction. On the same bit in the same cycle it takes priority over a synchronized change.
- R8: A side-channel update with `upd_drive` = 1 also writes `upd_level` into latch bit `upd_pin`, leaving the other latch bits unchanged. It takes priority over a bus write to that bit in the same cycle.
- R9: `irq` is set only by an update event (a synchronized change or a side-channel update) on a pin whose change-mask bit is 1. Events on unmasked pins leave `irq` low.
- R10: `irq` stays high until a cycle with `irq_ack` = 1 clears it. A masked event in the same cycle as the acknowledge keeps it high.
- R11: A read of address 3 returns the last byte written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write enable for this cycle |
| bus_addr | input | 2 | Register address (see R2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values, equal to the latch (per pin and as a byte) |
| pad_oe | output | 8 | Pad output enables, equal to the direction byte |
| upd_valid | input | 1 | Side-channel single-pin update |
| upd_pin | input | 3 | Pin index of the update |
| upd_level | input | 1 | Level written by the update |
| upd_drive | input | 1 | Also write the level into the latch |
| pin_raw | output | 8 | Stored levels, not merged with direction |
| port_stb | output | 1 | One-cycle pulse after any latch write |
| dir_stb | output | 1 | One-cycle pulse after a direction write; value on `pad_oe` |
| irq | output | 1 | Change interrupt request, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
Directed steps come first. They walk through the address map with a direction byte of 0xF0, so that a merged read mixes latch and level bits. Those reads would show a swapped merge or a wrong register decode. Toggle writes go to the level address, and the bench confirms that the stored levels stay put. The bench also counts edges on a pad change to pin down the synchronizer depth, and applies side-channel updates both with and without drive, on masked and unmasked pins. After that, thousands of random cycles mix bus writes, pad changes, side-channel updates and acknowledges, often in the same cycle. Those cycles exercise the priority rules and the set-while-acknowledge case against a bench model.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register selector and widths for the GPIO bank.
// Assumes an address field of two bits; the encoding is fixed by the map.
package gpio_bank_pkg;
    localparam int unsigned PINS = 8;

    typedef enum logic [1:0] {
        SEL_LEVEL   = 2'd0,
        SEL_DIR     = 2'd1,
        SEL_LATCH   = 2'd2,
        SEL_CHGMASK = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for pad inputs with change detection.
// Assumes pad inputs are asynchronous; chg marks bits where the last
// synchronized sample differs from the one before it.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] chg
);
    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    // first stage samples the raw pads
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // later stages shift the sample along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    // keep the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[STAGES-1];
    end

    assign level = stg[STAGES-1];
    assign chg   = stg[STAGES-1] ^ prev_q;

    // R6: a reported change means the synchronized level moved since last edge
    assert_chg_means_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> (level != $past(level)));
endmodule

// File: rtl/gpio_regs.sv
// Module: register file of the bank: level, direction, latch, change mask.
// Assumes one bus write per cycle; side-channel updates override bus and
// synchronizer on their own bit.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] sync_level,
    input  logic [WIDTH-1:0] sync_chg,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_pin,
    input  logic             upd_level,
    input  logic             upd_drive,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] event_vec,
    output logic             latch_stb,
    output logic             dir_stb
);
    logic [WIDTH-1:0] upd_hot;
    logic [WIDTH-1:0] level_d;
    logic [WIDTH-1:0] latch_d;
    logic             wr_level, wr_dir, wr_latch, wr_mask;

    assign upd_hot  = upd_valid ? (WIDTH'(1) << upd_pin) : '0;
    assign wr_level = bus_wr && (bus_addr == SEL_LEVEL);
    assign wr_dir   = bus_wr && (bus_addr == SEL_DIR);
    assign wr_latch = bus_wr && (bus_addr == SEL_LATCH);
    assign wr_mask  = bus_wr && (bus_addr == SEL_CHGMASK);

    // next level: synchronized changes first, side-channel bit overrides
    always_comb begin
        level_d = (level_q & ~sync_chg) | (sync_level & sync_chg);
        level_d = (level_d & ~upd_hot) | ({WIDTH{upd_level}} & upd_hot);
    end

    // next latch: bus load or toggle, then driving side-channel bit
    always_comb begin
        latch_d = latch_q;
        if (wr_latch)      latch_d = bus_wdata;
        else if (wr_level) latch_d = latch_q ^ bus_wdata;
        if (upd_drive)
            latch_d = (latch_d & ~upd_hot) | ({WIDTH{upd_level}} & upd_hot);
    end

    // register state and write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= '0;
            latch_q   <= '0;
            dir_q     <= '0;
            mask_q    <= '0;
            latch_stb <= 1'b0;
            dir_stb   <= 1'b0;
        end else begin
            level_q   <= level_d;
            latch_q   <= latch_d;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_mask) mask_q <= bus_wdata;
            latch_stb <= wr_latch || wr_level || (upd_valid && upd_drive);
            dir_stb   <= wr_dir;
        end
    end

    // read mux: merged view at the level address
    always_comb begin
        unique case (bus_addr)
            SEL_LEVEL:   bus_rdata = (level_q & ~dir_q) | (latch_q & dir_q);
            SEL_DIR:     bus_rdata = dir_q;
            SEL_LATCH:   bus_rdata = latch_q;
            default:     bus_rdata = mask_q;
        endcase
    end

    assign event_vec = sync_chg | upd_hot;

    // R4: a latch write without side-channel drive lands as written
    assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_latch && !(upd_valid && upd_drive)) |=> (latch_q == $past(bus_wdata)) && latch_stb);
    // R3: a level-address write toggles the latch and leaves levels alone
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_level && !upd_valid && !(|sync_chg)) |=>
            (latch_q == ($past(latch_q) ^ $past(bus_wdata))) && $stable(level_q));
    // R5: direction write lands with a one-cycle strobe
    assert_dir_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(bus_wdata)) && dir_stb);
    // R8: a non-driving update never changes the latch without a bus write
    assert_nodrive_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_drive && !wr_latch && !wr_level) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_irq.sv
// Module: sticky change-interrupt request with acknowledge.
// Assumes events arrive one cycle wide; a masked event wins over acknowledge.
module gpio_irq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] event_vec,
    input  logic [WIDTH-1:0] mask,
    input  logic             ack,
    output logic             irq
);
    logic hit;

    assign hit = |(event_vec & mask);

    // hold the request until acknowledged, set by any masked event
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (irq && !ack) || hit;
    end

    // R9: a request only rises after a masked event
    assert_rise_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(event_vec & mask)));
    // R10: without acknowledge the request holds
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    // R10: acknowledge with no masked event clears it
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(|(event_vec & mask))) |=> !irq);
endmodule

// File: rtl/gpio_bank8.sv
// Module: top of the eight-pin GPIO bank with change interrupt.
// Assumes a single-clock register bus; pads are asynchronous inputs.
module gpio_bank8
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH       = PINS,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_pin,
    input  logic             upd_level,
    input  logic             upd_drive,
    output logic [WIDTH-1:0] pin_raw,
    output logic             port_stb,
    output logic             dir_stb,
    output logic             irq,
    input  logic             irq_ack
);
    logic [WIDTH-1:0] s_level, s_chg;
    logic [WIDTH-1:0] latch_q, dir_q, level_q, mask_q, event_vec;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in),
        .level(s_level), .chg(s_chg)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_level(s_level), .sync_chg(s_chg),
        .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_level(upd_level), .upd_drive(upd_drive),
        .latch_q(latch_q), .dir_q(dir_q), .level_q(level_q), .mask_q(mask_q),
        .event_vec(event_vec), .latch_stb(port_stb), .dir_stb(dir_stb)
    );

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_vec(event_vec), .mask(mask_q),
        .ack(irq_ack), .irq(irq)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;
    assign pin_raw = level_q;

    // R1: one cycle out of reset everything is cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pad_oe == '0) && (pad_out == '0) && !irq);
endmodule

// File: tb/sim_gpio_bank8.sv
module sim_gpio_bank8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pin_raw;
    logic       upd_valid = 1'b0;
    logic [2:0] upd_pin = 3'd0;
    logic       upd_level = 1'b0;
    logic       upd_drive = 1'b0;
    logic       port_stb, dir_stb, irq;
    logic       irq_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic [7:0] m_lat, m_dir, m_lvl, m_msk, m_s1, m_s2, m_s3;
    logic       m_irq, m_pstb, m_dstb;

    always #4 clk = ~clk;   // 125 MHz

    gpio_bank8 u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .upd_valid(upd_valid), .upd_pin(upd_pin),
        .upd_level(upd_level), .upd_drive(upd_drive), .pin_raw(pin_raw),
        .port_stb(port_stb), .dir_stb(dir_stb), .irq(irq), .irq_ack(irq_ack)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return (m_lvl & ~m_dir) | (m_lat & m_dir);
            2'd1:    return m_dir;
            2'd2:    return m_lat;
            default: return m_msk;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lat = 0; m_dir = 0; m_lvl = 0; m_msk = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0;
        m_irq = 0; m_pstb = 0; m_dstb = 0;
    endtask

    // one clock: edge, model update from the applied inputs, then settle at negedge
    task automatic tick();
        logic [7:0] ev, hot, nl, nlat, ndir, nmsk;
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            ev   = m_s2 ^ m_s3;
            hot  = upd_valid ? (8'h01 << upd_pin) : 8'h00;
            nl   = (m_lvl & ~ev) | (m_s2 & ev);
            nl   = (nl & ~hot) | ({8{upd_level}} & hot);
            nlat = m_lat; ndir = m_dir; nmsk = m_msk;
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: nlat = m_lat ^ bus_wdata;
                    2'd1: ndir = bus_wdata;
                    2'd2: nlat = bus_wdata;
                    default: nmsk = bus_wdata;
                endcase
            end
            if (upd_drive) nlat = (nlat & ~hot) | ({8{upd_level}} & hot);
            m_irq  = (m_irq && !irq_ack) || (|((ev | hot) & m_msk));
            m_pstb = (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd2)) || (upd_valid && upd_drive);
            m_dstb = bus_wr && bus_addr == 2'd1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            m_lvl = nl; m_lat = nlat; m_dir = ndir; m_msk = nmsk;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 0; upd_valid = 0; upd_drive = 0; irq_ack = 0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic push(input logic [2:0] p, input logic l, input logic drv);
        upd_valid = 1; upd_pin = p; upd_level = l; upd_drive = drv;
        tick();
        upd_valid = 0; upd_drive = 0;
    endtask

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        model_reset();
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state on every address and output
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1 chk("R1 read", bus_rdata, 8'h00);
        end
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 out", pad_out, 8'h00);
        chk("R1 irq", irq, 0);
        // R5: direction write and strobe
        bus_write(2'd1, 8'hF0);
        chk("R5 oe", pad_oe, 8'hF0);
        chk("R5 stb", dir_stb, 1);
        tick();
        chk("R5 stb drop", dir_stb, 0);
        // R4: latch write
        bus_write(2'd2, 8'hA5);
        chk("R4 out", pad_out, 8'hA5);
        chk("R4 stb", port_stb, 1);
        // R3: toggle via level address, levels untouched
        bus_write(2'd0, 8'h0F);
        chk("R3 toggle", pad_out, 8'hAA);
        chk("R3 level kept", pin_raw, 8'h00);
        // R6: synchronizer depth
        pad_in = 8'h3C;
        tick(); tick();
        chk("R6 not yet", pin_raw, 8'h00);
        tick();
        chk("R6 arrived", pin_raw, 8'h3C);
        chk("R9 unmasked change", irq, 0);
        bus_addr = 2'd0;
        #1 chk("R2 merge", bus_rdata, 8'hAC);
        // R7: side-channel level, no drive
        push(3'd1, 1, 0);
        chk("R7 set bit1", pin_raw, 8'h3E);
        chk("R7 latch kept", pad_out, 8'hAA);
        push(3'd7, 1, 0);
        chk("R7 output pin level", pin_raw, 8'hBE);
        bus_addr = 2'd0;
        #1 chk("R2 merge2", bus_rdata, 8'hAE);
        chk("R9 unmasked update", irq, 0);
        // R8: driving updates
        push(3'd0, 1, 1);
        chk("R8 drive set", pad_out, 8'hAB);
        push(3'd3, 0, 1);
        chk("R8 drive clear", pad_out, 8'hA3);
        chk("R7 clear bit3", pin_raw, 8'hB7);
        // R11: mask readback
        bus_write(2'd3, 8'h01);
        bus_addr = 2'd3;
        #1 chk("R11 mask read", bus_rdata, 8'h01);
        // R9/R10: masked and unmasked events, hold and acknowledge
        push(3'd2, 0, 0);
        chk("R9 unmasked pin2", irq, 0);
        push(3'd0, 0, 0);
        chk("R9 masked pin0", irq, 1);
        repeat (4) tick();
        chk("R10 hold", irq, 1);
        irq_ack = 1; tick(); irq_ack = 0;
        chk("R10 ack clears", irq, 0);
        irq_ack = 1; push(3'd0, 1, 0); irq_ack = 0;
        chk("R10 ack with event", irq, 1);
        chk("R7 level", pin_raw, 8'hB3);
        irq_ack = 1; tick(); irq_ack = 0;
        chk("R10 ack again", irq, 0);
        // random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 2'($urandom);
            bus_wdata = 8'($urandom);
            if (($urandom % 4) == 0) pad_in = 8'($urandom);
            upd_valid = ($urandom % 3) == 0;
            upd_pin   = 3'($urandom);
            upd_level = 1'($urandom);
            upd_drive = 1'($urandom);
            irq_ack   = ($urandom % 5) == 0;
            tick();
            chk("R2/R11 rand read", bus_rdata, exp_read(bus_addr));
            chk("R4/R8 rand out", {pad_out, port_stb}, {m_lat, m_pstb});
            chk("R5 rand oe", {pad_oe, dir_stb}, {m_dir, m_dstb});
            chk("R6/R7 rand level", pin_raw, m_lvl);
            chk("R9/R10 rand irq", irq, m_irq);
        end
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule